// File: doc/BRIEF.md
# Auto-Ranging Frequency and Period Sequencer

This block runs a complete high-resolution reading of an unknown signal against a reference clock. It first counts input edges over a short window of reference cycles, a tenth of the long gate. It scales that count by ten to get a coarse frequency estimate, then picks one of two measurements.

A fast input gets a direct count of its edges over the long gate. A slower input gets a reciprocal measurement: the gate is held open for as many input edges as the estimate predicts for one second, and reference cycles are counted meanwhile. That keeps the gate close to the long gate time whatever the input rate.

The input is presented, once per reference cycle, as the number of input edges seen in that cycle. The block reports five results together:
- the final count;
- the gate preset value that an up-counting gate bank with a 256-early terminal flag would need;
- the mode;
- the number of count-bank wrap-arounds implied by the sample;
- a status.

A one-cycle valid pulse qualifies the results. A zero estimate ends the run with a no-signal status. A programmable limit aborts a period gate that never closes.

Top module: `autorange_freq_seq`

## Requirements
- R1: After reset, busy and res_valid are 0 and every result output is 0.
- R2: A start seen while idle raises busy on the next cycle. The sample is the sum of sig_edges over the REF_SHORT cycles that follow the accepting edge.
- R3: The estimate is the sample times REF_LONG/REF_SHORT. If it is at least REF_LONG, a frequency measurement follows. It skips one cycle, then sums sig_edges over REF_LONG cycles, modulo 2^CW. It reports res_mode=0 and res_preset = -(REF_LONG+255) mod 2^CW.
- R4: If the estimate lies between 1 and REF_LONG-1, a period measurement follows, after one skipped cycle. It counts reference cycles, including the cycle in which the running edge total first reaches the estimate. It reports that count modulo 2^CW, res_mode=1 and res_preset = -(estimate+255) mod 2^CW.
- R5: If the estimate is zero, no second measurement is made. The result (status 1, mode 1, count 0) is published at the edge after the sample ends.
- R6: res_wraps is the integer quotient of the sample divided by WRAP_DIV.
- R7: When the period gate has been open timeout_cycles cycles without closing, the run aborts with status 2 and count timeout_cycles. A frequency measurement never times out.
- R8: If the gate closes in the same cycle the timeout is reached, the close wins and the status is 0.
- R9: res_valid is high for exactly one cycle. The result outputs hold their values until the next result.
- R10: A start while busy has no effect on the running measurement or its result.
- R11: busy falls on the same edge that raises res_valid. The result latency counts from the start-accepting edge as follows:
  - frequency: REF_SHORT+1+REF_LONG cycles;
  - period closing in gate cycle c: REF_SHORT+1+c cycles;
  - no signal: REF_SHORT+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a reading (accepted when idle) |
| sig_edges | input | EDGE_W | Input edges seen in this reference cycle |
| timeout_cycles | input | TW | Period gate abort limit in reference cycles |
| busy | output | 1 | A reading is in progress |
| res_valid | output | 1 | One-cycle result qualifier |
| res_mode | output | 1 | 0 = frequency, 1 = period |
| res_status | output | 2 | 0 = ok, 1 = no signal, 2 = timeout |
| res_count | output | CW | Final count bank value |
| res_preset | output | CW | Gate bank preset value |
| res_wraps | output | WW | Count bank wrap-arounds |

## Verification
The gate close and the timeout abort can fall in one reference cycle. The bench first finds, from its own model, the gate cycle in which the edge total reaches the estimate. It then reruns the same input pattern with timeout_cycles set to exactly that cycle, where the close must win with status 0. A final run with the limit set one cycle lower must yield status 2 and the shorter count.

// File: rtl/autorange_freq_seq.sv
module autorange_freq_seq #(
  parameter int REF_LONG  = 10_000_000,
  parameter int REF_SHORT = 1_000_000,
  parameter int CW        = 24,
  parameter int WRAP_DIV  = 1_677_721,
  parameter int WW        = 4,
  parameter int EDGE_W    = 3,
  parameter int TW        = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [EDGE_W-1:0] sig_edges,
  input  logic [TW-1:0]     timeout_cycles,
  output logic              busy,
  output logic              res_valid,
  output logic              res_mode,
  output logic [1:0]        res_status,
  output logic [CW-1:0]     res_count,
  output logic [CW-1:0]     res_preset,
  output logic [WW-1:0]     res_wraps
);
  localparam int SCALE = REF_LONG / REF_SHORT;
  localparam int EW    = CW + $clog2(SCALE + 1);
  localparam int LW    = $clog2(REF_LONG + 1);
  localparam int TMW   = (TW > LW) ? TW : LW;
  localparam logic [CW-1:0] FREQ_PRESET = CW'(-(REF_LONG + 255));
  localparam logic [1:0] ST_OK = 2'd0, ST_NOSIG = 2'd1, ST_TMO = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_SAMPLE, S_DECIDE, S_FREQ, S_PER} state_t;

  state_t         state;
  logic [CW-1:0]  acc, sample;
  logic [TMW-1:0] tick;
  logic [EW-1:0]  gcnt;
  logic [EW-1:0]  est, per_sum;
  logic [CW-1:0]  acc_nx;
  logic [EW-1:0]  gcnt_nx;
  logic [TMW-1:0] tick_nx;

  assign est     = EW'(sample) * EW'(SCALE);
  assign per_sum = est + EW'(255);
  assign acc_nx  = acc + CW'(sig_edges);
  assign gcnt_nx = gcnt + EW'(sig_edges);
  assign tick_nx = tick + TMW'(1);
  assign busy    = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; acc <= '0; sample <= '0; tick <= '0; gcnt <= '0;
      res_valid <= 1'b0; res_mode <= 1'b0; res_status <= ST_OK;
      res_count <= '0; res_preset <= '0; res_wraps <= '0;
    end else begin
      res_valid <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state <= S_SAMPLE; acc <= '0; tick <= '0;
        end
        S_SAMPLE: begin
          acc  <= acc_nx;
          tick <= tick_nx;
          if (tick == TMW'(REF_SHORT - 1)) begin
            sample <= acc_nx;
            state  <= S_DECIDE;
          end
        end
        S_DECIDE: begin
          acc <= '0; tick <= '0; gcnt <= '0;
          if (est == '0) begin
            state <= S_IDLE; res_valid <= 1'b1; res_mode <= 1'b1;
            res_status <= ST_NOSIG; res_count <= '0;
            res_preset <= CW'(EW'(0) - per_sum);
            res_wraps <= WW'(sample / CW'(WRAP_DIV));
          end else if (est >= EW'(REF_LONG)) begin
            state <= S_FREQ;
          end else begin
            state <= S_PER;
          end
        end
        S_FREQ: begin
          acc  <= acc_nx;
          tick <= tick_nx;
          if (tick == TMW'(REF_LONG - 1)) begin
            state <= S_IDLE; res_valid <= 1'b1; res_mode <= 1'b0;
            res_status <= ST_OK; res_count <= acc_nx; res_preset <= FREQ_PRESET;
            res_wraps <= WW'(sample / CW'(WRAP_DIV));
          end
        end
        S_PER: begin
          gcnt <= gcnt_nx;
          tick <= tick_nx;
          if (gcnt_nx >= est || tick_nx >= TMW'(timeout_cycles)) begin
            state <= S_IDLE; res_valid <= 1'b1; res_mode <= 1'b1;
            res_status <= (gcnt_nx >= est) ? ST_OK : ST_TMO;
            res_count <= CW'(tick_nx);
            res_preset <= CW'(EW'(0) - per_sum);
            res_wraps <= WW'(sample / CW'(WRAP_DIV));
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FREQ && start) |=> (state == S_FREQ || res_valid));
  assert_freq_no_timeout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_mode) |-> (res_status == ST_OK));
  assert_nosig_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DECIDE && est == '0) |=> (res_valid && res_status == ST_NOSIG && !busy));
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !busy);
endmodule

// File: tb/autorange_freq_seq_tb.sv
module autorange_freq_seq_tb;
  localparam int CLK_P = 10;
  localparam int L = 200, S = 20, CW = 8, WD = 25, WW = 4, EDGE_W = 3, TW = 16;

  logic clk = 0, rst_n = 0, start = 0;
  logic [EDGE_W-1:0] sig_edges = '0;
  logic [TW-1:0] timeout_cycles = '1;
  logic busy, res_valid, res_mode;
  logic [1:0] res_status;
  logic [CW-1:0] res_count, res_preset;
  logic [WW-1:0] res_wraps;
  int checks = 0, failures = 0;

  always #(CLK_P/2) clk = ~clk;

  autorange_freq_seq #(.REF_LONG(L), .REF_SHORT(S), .CW(CW), .WRAP_DIV(WD),
    .WW(WW), .EDGE_W(EDGE_W), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sig_edges(sig_edges),
    .timeout_cycles(timeout_cycles), .busy(busy), .res_valid(res_valid),
    .res_mode(res_mode), .res_status(res_status), .res_count(res_count),
    .res_preset(res_preset), .res_wraps(res_wraps));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int pat(input int p, input int r, input int j);
    if (p == 0) return r;
    return (j % p == 0) ? 1 : 0;
  endfunction

  function automatic void model(input int p, input int r, input int tmo,
    output int mode, output int status, output int count, output int preset,
    output int wraps, output int lat);
    int s = 0, est, g = 0, c = 0;
    for (int j = 0; j < S; j++) s += pat(p, r, j);
    est = s * (L / S);
    wraps = (s / WD) % (1 << WW);
    if (est == 0) begin
      mode = 1; status = 1; count = 0; preset = (-255) & 255; lat = S + 2;
    end else if (est >= L) begin
      mode = 0; status = 0;
      for (int j = S + 1; j <= S + L; j++) c += pat(p, r, j);
      count = c & 255; preset = (-(L + 255)) & 255; lat = S + 2 + L;
    end else begin
      mode = 1; preset = (-(est + 255)) & 255; status = 2; count = 0; lat = 0;
      for (int k = 1; k < 100000; k++) begin
        g += pat(p, r, S + k);
        if (g >= est) begin status = 0; count = k & 255; lat = S + 2 + k; break; end
        if (k >= tmo) begin status = 2; count = k & 255; lat = S + 2 + k; break; end
      end
    end
  endfunction

  task automatic run_case(input int p, input int r, input int tmo, input bit poke, input string tag);
    int em, es, ec, ep, ew, el, n;
    logic [CW-1:0] hc;
    model(p, r, tmo, em, es, ec, ep, ew, el);
    timeout_cycles = TW'(tmo);
    @(negedge clk); start = 1; sig_edges = '0;
    @(negedge clk); start = 0; n = 1;
    chk(busy === 1'b1, "R2", {tag, " busy after start"}, int'(busy), 1);
    while (!res_valid && n < 5000) begin
      sig_edges = EDGE_W'(pat(p, r, n - 1));
      start = (poke && n == 40);
      @(negedge clk); n++;
    end
    start = 0; sig_edges = '0;
    chk(res_valid === 1'b1, "R11", {tag, " result seen"}, int'(res_valid), 1);
    chk(n == el, "R11", {tag, " latency"}, n, el);
    chk(busy === 1'b0, "R11", {tag, " busy low at valid"}, int'(busy), 0);
    chk(int'(res_mode) == em, em ? "R4" : "R3", {tag, " mode"}, int'(res_mode), em);
    chk(int'(res_status) == es, es == 1 ? "R5" : (es == 2 ? "R7" : "R8"), {tag, " status"}, int'(res_status), es);
    chk(int'(res_count) == ec, poke ? "R10" : (em ? "R4" : "R3"), {tag, " count"}, int'(res_count), ec);
    chk(int'(res_preset) == ep, em ? "R4" : "R3", {tag, " preset"}, int'(res_preset), ep);
    chk(int'(res_wraps) == ew, "R6", {tag, " wraps"}, int'(res_wraps), ew);
    hc = res_count;
    repeat (3) @(negedge clk);
    chk(res_valid === 1'b0, "R9", {tag, " valid single pulse"}, int'(res_valid), 0);
    chk(res_count === hc, "R9", {tag, " count held"}, int'(res_count), int'(hc));
  endtask

  initial begin
    #(CLK_P * 200000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int m, s2, c, p2, w, lat, p, r;
    void'($urandom(32'h1234_5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 1'b0 && res_valid === 1'b0, "R1", "reset flags", int'(busy) + int'(res_valid), 0);
    chk(res_count === '0 && res_preset === '0 && res_wraps === '0 && res_status === '0 && res_mode === 1'b0,
        "R1", "reset results", int'(res_count), 0);
    run_case(0, 1, 65535, 0, "freq x1");
    run_case(0, 3, 65535, 0, "freq x3 wraps");
    run_case(0, 2, 65535, 1, "freq start while busy");
    run_case(0, 0, 65535, 0, "no signal");
    run_case(2, 0, 65535, 0, "period p2");
    run_case(40, 0, 65535, 0, "period p40");
    model(3, 0, 65535, m, s2, c, p2, w, lat);
    run_case(3, 0, lat - S - 2, 0, "close ties timeout");
    run_case(3, 0, lat - S - 3, 0, "timeout one early");
    run_case(7, 0, 0, 0, "timeout zero");
    for (int i = 0; i < 10; i++) begin
      p = ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(2, 60));
      r = int'($urandom_range(1, 3));
      run_case(p, r, ($urandom_range(0, 2) == 0) ? int'($urandom_range(1, 300)) : 65535, 0, "random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule